// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends bytes one bit at a time over a clock line and a data line. It adds no start, stop or acknowledge framing. Software turns the block on, picks master or slave, and sets a 4-bit clock ratio. It then selects transmit, which raises the empty flag. While that flag is high, software writes a byte into the holding register. The byte moves into the shift register as soon as the shifter is free, and the empty flag comes back on its own. A byte written while another is still shifting waits in the holding register. It follows the current byte with no pause between them.

As master, the block makes the clock itself, drives it on the SCL output and enables the SCL driver. As slave, it synchronises an SCL input and runs on the edges of that input. In both roles the data line changes on the falling clock edge, least significant bit first, so the receiver samples it on the rising edge. When no byte is waiting, the master clock stops and stays high, and the data line keeps its last bit.

Top module: `sst_tx`

## Requirements
- R1: `scl_oe` is 1 exactly when `en` and `mst` are both 1. In slave mode the block never drives SCL.
- R2: After reset `tdre` is 0. `tdre` is 1 when `en` and `tx_sel` are 1 and the holding register is empty, so setting `tx_sel` on an idle, enabled block raises `tdre` in the same cycle.
- R3: A write (`wr_en` high while `en` and `tx_sel` are 1) clears `tdre` after the next clock edge. If the shifter is idle, the byte moves to the shifter on the following edge and `tdre` is 1 again, so `tdre` is low for exactly one cycle.
- R4: Each byte goes out least significant bit first, one bit per SCL period. In master mode `sda_o` changes only on the system clock edge where `scl_o` falls. A receiver sampling on the SCL rising edge reads back the written byte.
- R5: In master mode one SCL period is 2*(clk_sel+1)*HALF_UNIT system clocks, with equal high and low halves. After a write to an idle block, `scl_o` first falls HALF_UNIT*(clk_sel+1)+1 clocks after the write edge.
- R6: A byte written while another is shifting waits with `tdre` low. It moves to the shifter at the falling edge that follows the 8th bit, so SCL keeps an unchanged period across the byte boundary.
- R7: With no byte left, SCL stops high after the 8th rising edge, `sda_o` keeps the last bit sent (bit 7), and SCL stays high for as long as the shifter is idle.
- R8: In slave mode the block shifts on falling edges of `scl_in`, through a two-flop synchroniser. The last byte ends on the 8th rising edge, and a waiting byte follows on the next falling edge.
- R9: A write while `en` or `tx_sel` is 0 is dropped. `tdre` stays low while it is 0, becomes 1 once transmit is enabled, and no SCL activity follows.
- R10: Clearing `en` drops any byte in progress and any byte waiting. The shifter goes idle with `scl_o` high and `sda_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| mst | input | 1 | 1: generate SCL, 0: take SCL from `scl_in` |
| clk_sel | input | 4 | Master clock ratio select |
| tx_sel | input | 1 | 1: transmit selected |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| scl_in | input | 1 | External SCL in slave mode |
| scl_o | output | 1 | Generated SCL level |
| scl_oe | output | 1 | SCL driver enable |
| sda_o | output | 1 | Serial data out |
| tdre | output | 1 | Transmit data register empty flag |

## Verification
The bench looks for a gap or a stretched period at the byte hand-off. A design that moves the waiting byte one edge late, or restarts the divider there, shows a longer interval between falling edges in the middle of a burst. It checks bit order and the edge on which data changes by capturing the line on every rising SCL edge. A reversed shift or data that changes on the rising edge then gives wrong bytes. It times the first falling edge and the `tdre` pulse after a write to an idle block, which catches an extra pipeline stage or a flag that fails to set again. It also checks dropped writes, an abort by disable, the level SCL is left at when it stops, and slave operation driven from `scl_in`, where a wrong synchroniser edge corrupts the bytes.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);
  localparam int SEL_W    = 4;

  typedef struct packed {
    logic fall;
    logic rise;
  } scl_ev_t;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen
  import sst_pkg::*;
#(
  parameter int HALF_UNIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mst,
  input  logic             busy,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             scl_in,
  output logic             scl_q,
  output scl_ev_t          ev
);
  localparam int HALF_MAX = (1 << SEL_W) * HALF_UNIT;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             scl_d;
  logic             run, tick;
  logic             s_meta_q, s_sync_q, s_prev_q;

  always_comb begin
    lim   = CNT_W'((int'(clk_sel) + 1) * HALF_UNIT - 1);
    run   = en & mst & busy;
    tick  = run & (cnt_q == lim);
    cnt_d = cnt_q;
    scl_d = scl_q;
    if (!run) begin
      cnt_d = '0;
      scl_d = 1'b1;
    end else if (tick) begin
      cnt_d = '0;
      scl_d = ~scl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (mst) begin
      ev.fall = tick & scl_q;
      ev.rise = tick & ~scl_q;
    end else begin
      ev.fall = en & s_prev_q & ~s_sync_q;
      ev.rise = en & ~s_prev_q & s_sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      scl_q    <= 1'b1;
      s_meta_q <= 1'b1;
      s_sync_q <= 1'b1;
      s_prev_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      scl_q    <= scl_d;
      s_meta_q <= scl_in;
      s_sync_q <= s_meta_q;
      s_prev_q <= s_sync_q;
    end
  end

  // R7
  scl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> scl_q);
endmodule

// File: rtl/sst_holdreg.sv
module sst_holdreg
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_ok,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              take,
  output logic              full_q,
  output logic [BYTE_W-1:0] data_q
);
  logic full_d;

  always_comb begin
    if (flush) full_d = 1'b0;
    else       full_d = wr_ok | (full_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_ok) data_q <= wdata;
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  scl_ev_t           ev,
  input  logic              full,
  input  logic [BYTE_W-1:0] hold,
  output logic              take,
  output logic              busy_q,
  output logic              sda_q
);
  localparam logic [BITCNT_W-1:0] LAST = BITCNT_W'(BYTE_W);

  logic                busy_d, sda_d;
  logic [BITCNT_W-1:0] nb_q, nb_d;
  logic [BYTE_W-1:0]   sr_q, sr_d;

  always_comb begin
    take   = 1'b0;
    busy_d = busy_q;
    nb_d   = nb_q;
    sr_d   = sr_q;
    sda_d  = sda_q;
    if (flush) begin
      busy_d = 1'b0;
      nb_d   = '0;
      sda_d  = 1'b1;
    end else if (!busy_q) begin
      if (full) begin
        take   = 1'b1;
        busy_d = 1'b1;
        nb_d   = '0;
        sr_d   = hold;
      end
    end else if (ev.fall) begin
      if (nb_q == LAST) begin
        if (full) begin
          take  = 1'b1;
          sda_d = hold[0];
          sr_d  = {1'b0, hold[BYTE_W-1:1]};
          nb_d  = BITCNT_W'(1);
        end else begin
          busy_d = 1'b0;
        end
      end else begin
        sda_d = sr_q[0];
        sr_d  = {1'b0, sr_q[BYTE_W-1:1]};
        nb_d  = nb_q + 1'b1;
      end
    end else if (ev.rise && nb_q == LAST && !full) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nb_q   <= '0;
      sr_q   <= '0;
      sda_q  <= 1'b1;
    end else begin
      busy_q <= busy_d;
      nb_q   <= nb_d;
      sr_q   <= sr_d;
      sda_q  <= sda_d;
    end
  end

  // R4
  nb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nb_q <= LAST);
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int HALF_UNIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mst,
  input  logic [3:0]       clk_sel,
  input  logic             tx_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             scl_oe,
  output logic             sda_o,
  output logic             tdre
);
  logic              wr_ok, flush, take, full, busy;
  logic [BYTE_W-1:0] hold;
  scl_ev_t           ev;

  assign wr_ok  = wr_en & en & tx_sel;
  assign flush  = ~en;
  assign tdre   = en & tx_sel & ~full;
  assign scl_oe = en & mst;

  sst_clkgen #(.HALF_UNIT(HALF_UNIT)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .busy(busy),
    .clk_sel(clk_sel), .scl_in(scl_in), .scl_q(scl_o), .ev(ev)
  );

  sst_holdreg u_hold (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_ok(wr_ok),
    .wdata(wr_data), .take(take), .full_q(full), .data_q(hold)
  );

  sst_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ev(ev), .full(full),
    .hold(hold), .take(take), .busy_q(busy), .sda_q(sda_o)
  );

  // R4
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && en && $past(en) && !$stable(sda_o)) |-> $fell(scl_o));

  // R7
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && en && $past(en)) |-> $stable(sda_o));

  // R7
  scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> scl_o);

  // R3
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en && tx_sel && $stable(en) && $stable(tx_sel)) |=> (!tdre || !en || !tx_sel));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !busy && en) |=> (busy || !en));
endmodule

// File: tb/sim_sst_tx.sv
module sim_sst_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HU = 2;

  logic clk, rst_n, en, mst, tx_sel, wr_en, scl_in_d;
  logic [3:0] clk_sel;
  logic [7:0] wr_data;
  logic scl_o, scl_oe, sda_o, tdre;

  sst_tx #(.HALF_UNIT(HU)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mst(mst), .clk_sel(clk_sel),
    .tx_sel(tx_sel), .wr_en(wr_en), .wr_data(wr_data), .scl_in(scl_in_d),
    .scl_o(scl_o), .scl_oe(scl_oe), .sda_o(sda_o), .tdre(tdre)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] exp_q [0:1023];
  int wp = 0, rp = 0;
  int rxbits = 0;
  logic [7:0] rxb = 0;
  logic prev_line = 1'b1;
  int cyc = 0, nfall = 0;
  int last_fall = -1, min_int = 0, max_int = 0, nint = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_raw(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    exp_q[wp] = b; wp++;
    wr_raw(b);
  endtask

  task automatic wait_tdre();
    while (!tdre) @(negedge clk);
  endtask

  task automatic wait_drained();
    while (rp != wp) @(negedge clk);
    tick(4);
  endtask

  task automatic stat_clr();
    last_fall = -1; min_int = 1 << 30; max_int = 0; nint = 0;
  endtask

  task automatic pulses(input int n);
    repeat (n) begin
      scl_in_d = 1'b0; tick(10);
      scl_in_d = 1'b1; tick(10);
    end
  endtask

  // receiver model: capture on rising SCL, track falling-edge spacing
  always @(negedge clk) begin
    logic line;
    cyc++;
    line = scl_oe ? scl_o : scl_in_d;
    if (!prev_line && line) begin
      rxb = {sda_o, rxb[7:1]};
      rxbits++;
      if (rxbits == 8) begin
        rxbits = 0;
        if (rp < wp) begin
          chk(rxb == exp_q[rp], "R4 byte", rxb, exp_q[rp]);
          rp++;
        end else begin
          chk(1'b0, "R9 unexpected byte", rxb, 0);
        end
      end
    end
    if (prev_line && !line) begin
      nfall++;
      if (last_fall >= 0) begin
        if (cyc - last_fall < min_int) min_int = cyc - last_fall;
        if (cyc - last_fall > max_int) max_int = cyc - last_fall;
        nint++;
      end
      last_fall = cyc;
    end
    prev_line = line;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int k, h, f0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; mst = 1'b0; tx_sel = 1'b0; wr_en = 1'b0;
    wr_data = '0; clk_sel = '0; scl_in_d = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk(tdre == 1'b0, "R2 reset tdre", tdre, 0);
    chk(scl_o == 1'b1, "R7 reset scl", scl_o, 1);
    chk(sda_o == 1'b1, "R10 reset sda", sda_o, 1);
    chk(scl_oe == 1'b0, "R1 oe disabled", scl_oe, 0);

    // master, write while not transmitting is dropped
    en = 1'b1; mst = 1'b1; clk_sel = 4'd0;
    tick(1);
    chk(scl_oe == 1'b1, "R1 oe master", scl_oe, 1);
    wr_raw(8'hA5);
    chk(tdre == 1'b0, "R9 tdre tx off", tdre, 0);
    f0 = nfall; tick(40);
    chk(nfall == f0, "R9 no scl", nfall - f0, 0);
    tx_sel = 1'b1;
    #1;
    chk(tdre == 1'b1, "R2 tdre on tx_sel", tdre, 1);
    tick(20);
    chk(nfall == f0, "R9 dropped byte stays dropped", nfall - f0, 0);

    // single byte timing, sel=1
    clk_sel = 4'd1; h = 2 * HU;
    tick(1); stat_clr();
    put(8'h3C);
    chk(tdre == 1'b0, "R3 tdre cleared", tdre, 0);
    tick(1);
    chk(tdre == 1'b1, "R3 tdre set again", tdre, 1);
    k = 1;
    while (scl_o) begin tick(1); k++; end
    chk(k == h + 1, "R5 first fall delay", k, h + 1);
    chk(sda_o == 1'b0, "R4 bit0 at first fall", sda_o, 0);
    wait_drained();
    chk(min_int == 2 * h && max_int == 2 * h, "R5 period", max_int, 2 * h);
    tick(20);
    chk(scl_o == 1'b1, "R7 scl stops high", scl_o, 1);
    chk(sda_o == 1'b0, "R7 sda holds bit7", sda_o, 0);
    chk(tdre == 1'b1, "R7 tdre idle", tdre, 1);

    // back-to-back, sel=0
    clk_sel = 4'd0; h = HU;
    tick(1); stat_clr();
    put(8'h81);
    wait_tdre();
    put(8'h5A);
    chk(tdre == 1'b0, "R6 byte waits", tdre, 0);
    wait_tdre();
    put(8'hF0);
    wait_drained();
    chk(min_int == 2 * h && max_int == 2 * h, "R6 no gap", max_int, 2 * h);
    chk(nint == 23, "R6 fall count", nint, 23);
    chk(sda_o == 1'b1, "R7 sda holds bit7 of F0", sda_o, 1);

    // abort by disable
    clk_sel = 4'd3;
    tick(1);
    put(8'h00);
    tick(30);
    en = 1'b0;
    tick(2);
    wp--; rxbits = 0;
    chk(scl_o == 1'b1, "R10 scl high after abort", scl_o, 1);
    chk(sda_o == 1'b1, "R10 sda high after abort", sda_o, 1);
    chk(tdre == 1'b0, "R2 tdre off when disabled", tdre, 0);
    wr_raw(8'h77);
    en = 1'b1;
    #1;
    chk(tdre == 1'b1, "R9 write while disabled dropped", tdre, 1);
    f0 = nfall; tick(80);
    chk(nfall == f0, "R10 no activity after abort", nfall - f0, 0);

    // slave mode
    mst = 1'b0;
    tick(1);
    chk(scl_oe == 1'b0, "R1 oe slave", scl_oe, 0);
    put(8'h69);
    wait_tdre();
    put(8'h96);
    tick(30);
    chk(tdre == 1'b0, "R8 waits for external clock", tdre, 0);
    pulses(16);
    tick(5);
    chk(rp == wp, "R8 slave bytes out", rp, wp);
    chk(tdre == 1'b1, "R8 tdre after slave burst", tdre, 1);
    chk(sda_o == 1'b1, "R7 slave sda holds bit7", sda_o, 1);

    // constrained random master traffic
    mst = 1'b1;
    tick(2);
    for (int g = 0; g < 40; g++) begin
      int n;
      clk_sel = 4'($urandom % 4);
      tick(1);
      n = 1 + ($urandom % 3);
      for (int i = 0; i < n; i++) begin
        wait_tdre();
        tick($urandom % 3);
        put(8'($urandom));
      end
      wait_drained();
      chk(scl_o == 1'b1, "R7 random idle scl", scl_o, 1);
    end
    chk(rp == wp, "R4 all random bytes", rp, wp);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule